// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Monitor

This block is the digital front end of a two-loop frequency synthesizer. Each of the two channels takes a reference pulse from its reference divider and a feedback pulse from its loop divider. A two-flag phase-frequency detector turns the time between those pulses into pump-up and pump-down requests for an external charge pump. The role of each request follows a per-channel sense bit. A shared float request, or a per-channel power-down, silences the requests and asks the pump to go high impedance. The pump current-select bit is not interpreted here; it is only passed through.

A lock watcher on each channel measures every comparison in clock cycles. A channel becomes locked after a run of consecutive small errors, and any error that grows too large drops it out of lock at once. One shared monitor pin is driven from a 2-bit output-select field and a 2-bit lock-select field, each holding one bit per channel. Depending on those fields the pin shows one or both lock flags, or one channel's reference or feedback divider pulse, or it stays low. When it stays low because both output-select bits are set, the block instead raises per-channel counter-clear requests.

All pulse inputs are one-cycle strobes synchronous to `clk`. In every 2-bit vector, bit 1 belongs to the high-frequency channel (channel A) and bit 0 to the low-frequency channel (channel B).

Top module: `dual_pfd_monitor`

## Requirements
- R1: With sense set, a reference strobe arriving while no flag is pending makes `up` high from the next cycle on. It stays high until the edge at which a feedback strobe arrives, and after that edge both `up` and `dn` are low. A feedback strobe that leads does the same on `dn`. Reference and feedback strobes in the same cycle produce no request at all.
- R2: With `sense_pos[c]`=0, the reference-lead flag drives `dn[c]` and the feedback-lead flag drives `up[c]`. This takes effect in the same cycle.
- R3: While `tristate_all`=1, `hiz` is 2'b11 and all `up`/`dn` bits are 0 in the same cycle. The pending flags are kept, and they show again once the float request is released.
- R4: While `pwr_dn[c]`=1, `hiz[c]`=1 and the requests of channel c are 0 in the same cycle. The channel's pending flags and lock state are cleared at the next edge. The other channel is unaffected.
- R5: A channel becomes locked at the edge of the LOCK_RUNS-th consecutive comparison whose error is below LOCK_WIN cycles (defaults 8 and 4). The error is the number of cycles between the leading and the trailing strobe, and 0 for coincident strobes.
- R6: Once a pending error reaches LOCK_WIN cycles, the lock and the run count of that channel are cleared at the next edge.
- R7: The lock flag a channel shows on the monitor is its lock state gated low while either of its lead flags is pending. This gives narrow low excursions while locked.
- R8: The monitor pin is registered, so it follows its selection one cycle later. With `fo_cfg`=2'b00 it shows: 0 for `ld_cfg`=2'b00, the selected channel's lock flag for 2'b01 or 2'b10, and the AND of both lock flags for 2'b11.
- R9: With exactly one `fo_cfg` bit set, the pin shows that channel's reference strobe when `ld_cfg[0]`=0 and its feedback strobe when `ld_cfg[0]`=1. `ld_cfg[1]` is ignored in this mode.
- R10: With `fo_cfg`=2'b11, the pin is 0 and the registered `ctr_clr` equals `ld_cfg`. In every other mode `ctr_clr` is 2'b00.
- R11: `pump_hi_out` equals `pump_hi_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ref_pls | input | 2 | Reference divider strobes, one per channel |
| fb_pls | input | 2 | Feedback divider strobes, one per channel |
| sense_pos | input | 2 | Per-channel phase sense (1 = positive tuning slope) |
| tristate_all | input | 1 | Float both pump outputs |
| pwr_dn | input | 2 | Per-channel power-down |
| pump_hi_in | input | 2 | Pump current select, passed through |
| fo_cfg | input | 2 | Monitor output-select bits, one per channel |
| ld_cfg | input | 2 | Monitor lock-select bits, one per channel |
| up | output | 2 | Pump-up requests |
| dn | output | 2 | Pump-down requests |
| hiz | output | 2 | Pump high-impedance requests |
| pump_hi_out | output | 2 | Pump current select to the pump |
| mon_pin | output | 1 | Shared monitor output |
| ctr_clr | output | 2 | Per-channel divider counter-clear requests |

## Verification
The embedded properties check several rules on every cycle. A resolved comparison always leaves both lead flags clear, and power-down empties a channel by the next edge. A large error always drops lock, lock only rises on a comparison, and floating silences every request. The monitor is quiet in its off and counter-clear modes, and clear requests appear only when both output-select bits are set. The directed scenarios show what the properties cannot express in a few cycles. These are the exact count of good comparisons needed for lock, the error boundary at LOCK_WIN cycles, the sense swap, and the routing of each divider strobe and lock combination to the shared pin.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int NCH = 2;

  typedef enum logic [2:0] {
    MON_OFF,
    MON_LOCK,
    MON_REF,
    MON_FB,
    MON_CLR
  } mon_mode_e;

  typedef struct packed {
    mon_mode_e  mode;
    logic [1:0] chan;   // one bit per channel, bit 1 = channel A
  } mon_dec_t;

  // Output-select and lock-select fields to monitor mode
  function automatic mon_dec_t decode_monitor(input logic [1:0] fo, input logic [1:0] ld);
    mon_dec_t d;
    d.mode = MON_OFF;
    d.chan = 2'b00;
    case (fo)
      2'b00: begin
        d.mode = (ld == 2'b00) ? MON_OFF : MON_LOCK;
        d.chan = ld;
      end
      2'b01, 2'b10: begin
        d.mode = ld[0] ? MON_FB : MON_REF;
        d.chan = fo;
      end
      default: begin
        d.mode = (ld == 2'b00) ? MON_OFF : MON_CLR;
        d.chan = ld;
      end
    endcase
    return d;
  endfunction

  // Next state of the two lead flags: {ref_lead, fb_lead}
  function automatic logic [1:0] pfd_next(input logic ref_q, input logic fb_q,
                                          input logic ref_p, input logic fb_p);
    logic r, f;
    r = ref_q | ref_p;
    f = fb_q | fb_p;
    return (r & f) ? 2'b00 : {r, f};
  endfunction

  // Map lead flags to {up, dn} under the sense bit
  function automatic logic [1:0] apply_sense(input logic ref_lead, input logic fb_lead,
                                             input logic pos);
    return pos ? {ref_lead, fb_lead} : {fb_lead, ref_lead};
  endfunction

  function automatic logic within_window(input int unsigned err, input int unsigned win);
    return err < win;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_p,
  input  logic fb_p,
  input  logic pos_sense,
  input  logic pd,
  input  logic float_req,
  output logic up,
  output logic dn,
  output logic hiz,
  output logic cmp_evt,
  output logic pend,
  output logic pend_nxt
);

  logic       ref_q, fb_q;
  logic [1:0] nxt;
  logic [1:0] ud;

  always_comb begin
    nxt      = pfd_next(ref_q, fb_q, ref_p, fb_p);
    cmp_evt  = ~pd & (ref_q | ref_p) & (fb_q | fb_p);
    pend     = ref_q | fb_q;
    pend_nxt = ~pd & (|nxt);
    ud       = apply_sense(ref_q, fb_q, pos_sense);
    up       = ud[1] & ~float_req;
    dn       = ud[0] & ~float_req;
    hiz      = float_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= nxt[1];
      fb_q  <= nxt[0];
    end
  end

  assert_resolve_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> (!ref_q && !fb_q));

  assert_pd_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!ref_q && !fb_q));

endmodule

// File: rtl/lock_watch.sv
module lock_watch
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN  = 4,
  parameter int LOCK_RUNS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic pend,
  input  logic pend_nxt,
  input  logic cmp_evt,
  output logic lock_flag
);

  localparam int ERR_W = $clog2(LOCK_WIN + 1);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [ERR_W-1:0] WIN_V  = ERR_W'(LOCK_WIN);
  localparam logic [RUN_W-1:0] RUNS_V = RUN_W'(LOCK_RUNS);
  localparam logic [RUN_W-1:0] LAST_V = RUN_W'(LOCK_RUNS - 1);

  logic [ERR_W-1:0] err_cnt;
  logic [RUN_W-1:0] runs;
  logic             locked;
  logic             bad_err, good_cmp;

  always_comb begin
    bad_err   = pend & (err_cnt >= WIN_V);
    good_cmp  = cmp_evt & within_window(32'(err_cnt), LOCK_WIN);
    lock_flag = locked & ~pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd) begin
      err_cnt <= '0;
    end else if (pend_nxt) begin
      err_cnt <= (err_cnt == WIN_V) ? WIN_V : err_cnt + 1'b1;
    end else begin
      err_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pd || bad_err) begin
      runs   <= '0;
      locked <= 1'b0;
    end else if (good_cmp) begin
      runs   <= (runs == RUNS_V) ? RUNS_V : runs + 1'b1;
      locked <= locked | (runs >= LAST_V);
    end
  end

  assert_big_error_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_err |=> !locked);

  assert_lock_on_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_evt));

endmodule

// File: rtl/mon_select.sv
module mon_select
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fo,
  input  logic [1:0]       ld,
  input  logic [NCH-1:0]   lock_flag,
  input  logic [NCH-1:0]   ref_p,
  input  logic [NCH-1:0]   fb_p,
  output logic             mon,
  output logic [NCH-1:0]   ctr_clr
);

  mon_dec_t       dec;
  logic           mon_nxt;
  logic [NCH-1:0] clr_nxt;

  always_comb begin
    dec     = decode_monitor(fo, ld);
    clr_nxt = '0;
    case (dec.mode)
      MON_LOCK: mon_nxt = &(lock_flag | ~dec.chan);
      MON_REF:  mon_nxt = |(ref_p & dec.chan);
      MON_FB:   mon_nxt = |(fb_p & dec.chan);
      MON_CLR: begin
        mon_nxt = 1'b0;
        clr_nxt = dec.chan;
      end
      default:  mon_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon     <= 1'b0;
      ctr_clr <= '0;
    end else begin
      mon     <= mon_nxt;
      ctr_clr <= clr_nxt;
    end
  end

  assert_off_mode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fo == 2'b00 && ld == 2'b00) |=> !mon);

  assert_clear_mode_pin_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fo == 2'b11) |=> !mon);

  assert_clear_only_when_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fo != 2'b11) |=> (ctr_clr == '0));

endmodule

// File: rtl/dual_pfd_monitor.sv
module dual_pfd_monitor
  import pfd_pkg::*;
#(
  parameter int LOCK_WIN  = 4,
  parameter int LOCK_RUNS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pls,
  input  logic [1:0] fb_pls,
  input  logic [1:0] sense_pos,
  input  logic       tristate_all,
  input  logic [1:0] pwr_dn,
  input  logic [1:0] pump_hi_in,
  input  logic [1:0] fo_cfg,
  input  logic [1:0] ld_cfg,
  output logic [1:0] up,
  output logic [1:0] dn,
  output logic [1:0] hiz,
  output logic [1:0] pump_hi_out,
  output logic       mon_pin,
  output logic [1:0] ctr_clr
);

  logic [NCH-1:0] lock_flag;

  assign pump_hi_out = pump_hi_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pend, pend_nxt, cmp_evt;

    pfd_core u_pfd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_p     (ref_pls[c]),
      .fb_p      (fb_pls[c]),
      .pos_sense (sense_pos[c]),
      .pd        (pwr_dn[c]),
      .float_req (tristate_all | pwr_dn[c]),
      .up        (up[c]),
      .dn        (dn[c]),
      .hiz       (hiz[c]),
      .cmp_evt   (cmp_evt),
      .pend      (pend),
      .pend_nxt  (pend_nxt)
    );

    lock_watch #(.LOCK_WIN(LOCK_WIN), .LOCK_RUNS(LOCK_RUNS)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd        (pwr_dn[c]),
      .pend      (pend),
      .pend_nxt  (pend_nxt),
      .cmp_evt   (cmp_evt),
      .lock_flag (lock_flag[c])
    );
  end

  mon_select u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .fo        (fo_cfg),
    .ld        (ld_cfg),
    .lock_flag (lock_flag),
    .ref_p     (ref_pls),
    .fb_p      (fb_pls),
    .mon       (mon_pin),
    .ctr_clr   (ctr_clr)
  );

  assert_float_silences_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_all |-> (hiz == 2'b11 && up == 2'b00 && dn == 2'b00));

endmodule

// File: tb/dual_pfd_monitor_tb.sv
module dual_pfd_monitor_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_pls = '0, fb_pls = '0, sense_pos = 2'b11, pwr_dn = '0;
  logic [1:0] pump_hi_in = '0, fo_cfg = '0, ld_cfg = '0;
  logic       tristate_all = 1'b0;
  logic [1:0] up, dn, hiz, pump_hi_out, ctr_clr;
  logic       mon_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_pfd_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .fb_pls(fb_pls),
    .sense_pos(sense_pos), .tristate_all(tristate_all), .pwr_dn(pwr_dn),
    .pump_hi_in(pump_hi_in), .fo_cfg(fo_cfg), .ld_cfg(ld_cfg),
    .up(up), .dn(dn), .hiz(hiz), .pump_hi_out(pump_hi_out),
    .mon_pin(mon_pin), .ctr_clr(ctr_clr)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] r, input logic [1:0] f);
    ref_pls = r; fb_pls = f;
    step();
    ref_pls = '0; fb_pls = '0;
  endtask

  task automatic clear_all();
    pwr_dn = 2'b11; step();
    pwr_dn = 2'b00; step();
  endtask

  // one comparison with error 'gap' cycles on the channels in 'mask'
  task automatic compare(input logic [1:0] mask, input int gap);
    pulse(mask, 2'b00);
    step(gap - 1);
    pulse(2'b00, mask);
  endtask

  task automatic test_reset();
    chk("R1", "reset up", {6'b0, up}, 8'h0);
    chk("R1", "reset dn", {6'b0, dn}, 8'h0);
    chk("R8", "reset mon", {7'b0, mon_pin}, 8'h0);
    chk("R10", "reset ctr_clr", {6'b0, ctr_clr}, 8'h0);
  endtask

  task automatic test_pfd_r1_r2();
    clear_all();
    pulse(2'b10, 2'b00);
    chk("R1", "ref lead up", {6'b0, up}, 8'h2);
    chk("R1", "ref lead dn", {6'b0, dn}, 8'h0);
    step(2);
    chk("R1", "ref lead held", {6'b0, up}, 8'h2);
    pulse(2'b00, 2'b10);
    chk("R1", "resolved up", {6'b0, up}, 8'h0);
    chk("R1", "resolved dn", {6'b0, dn}, 8'h0);
    pulse(2'b10, 2'b10);
    chk("R1", "coincident", {4'b0, up, dn}, 8'h0);
    pulse(2'b00, 2'b01);
    chk("R1", "fb lead dn", {4'b0, up, dn}, 8'h1);
    sense_pos = 2'b10; #1;
    chk("R2", "swapped sense", {4'b0, up, dn}, 8'h4);
    sense_pos = 2'b11;
    pulse(2'b01, 2'b00);
    chk("R1", "late ref clears", {4'b0, up, dn}, 8'h0);
  endtask

  task automatic test_float_r3();
    pulse(2'b00, 2'b10);
    tristate_all = 1'b1; #1;
    chk("R3", "float hiz", {6'b0, hiz}, 8'h3);
    chk("R3", "float quiet", {4'b0, up, dn}, 8'h0);
    step();
    tristate_all = 1'b0; #1;
    chk("R3", "flag kept", {4'b0, up, dn}, 8'h2);
    pulse(2'b10, 2'b00);
    chk("R3", "cleaned", {4'b0, up, dn}, 8'h0);
  endtask

  task automatic test_pd_r4();
    pulse(2'b11, 2'b00);
    pwr_dn = 2'b01; #1;
    chk("R4", "pd hiz", {6'b0, hiz}, 8'h1);
    chk("R4", "pd quiet ch B only", {6'b0, up}, 8'h2);
    step();
    pwr_dn = 2'b00; step();
    chk("R4", "ch B emptied, ch A kept", {6'b0, up}, 8'h2);
    pulse(2'b00, 2'b10);
    chk("R4", "ch A resolved", {4'b0, up, dn}, 8'h0);
  endtask

  task automatic test_pump_r11();
    pump_hi_in = 2'b10; #1;
    chk("R11", "pump pass 10", {6'b0, pump_hi_out}, 8'h2);
    pump_hi_in = 2'b01; #1;
    chk("R11", "pump pass 01", {6'b0, pump_hi_out}, 8'h1);
    pump_hi_in = 2'b00;
  endtask

  task automatic test_lock_r5_r6_r7();
    clear_all();
    fo_cfg = 2'b00; ld_cfg = 2'b10;
    for (int k = 0; k < 7; k++) compare(2'b10, 3);
    step();
    chk("R5", "not locked after 7", {7'b0, mon_pin}, 8'h0);
    compare(2'b10, 3);
    step();
    chk("R5", "locked after 8", {7'b0, mon_pin}, 8'h1);
    pulse(2'b10, 2'b00);
    step();
    chk("R7", "low excursion", {7'b0, mon_pin}, 8'h0);
    pulse(2'b00, 2'b10);
    step();
    chk("R7", "back high", {7'b0, mon_pin}, 8'h1);
    compare(2'b10, 4);
    step();
    chk("R6", "error of LOCK_WIN unlocks", {7'b0, mon_pin}, 8'h0);
  endtask

  task automatic test_lock_select_r8();
    clear_all();
    for (int k = 0; k < 8; k++) compare(2'b11, 2);
    ld_cfg = 2'b11; step();
    chk("R8", "AND both locked", {7'b0, mon_pin}, 8'h1);
    ld_cfg = 2'b01; step();
    chk("R8", "ch B lock", {7'b0, mon_pin}, 8'h1);
    ld_cfg = 2'b00; step();
    chk("R8", "off", {7'b0, mon_pin}, 8'h0);
    compare(2'b01, 5);
    ld_cfg = 2'b11; step();
    chk("R8", "AND one unlocked", {7'b0, mon_pin}, 8'h0);
    ld_cfg = 2'b10; step();
    chk("R8", "ch A still locked", {7'b0, mon_pin}, 8'h1);
    ld_cfg = 2'b01; step();
    chk("R8", "ch B unlocked", {7'b0, mon_pin}, 8'h0);
  endtask

  task automatic test_divider_r9();
    clear_all();
    fo_cfg = 2'b10; ld_cfg = 2'b00;
    pulse(2'b10, 2'b00);
    chk("R9", "ch A ref shown", {7'b0, mon_pin}, 8'h1);
    step();
    chk("R9", "ch A ref gone", {7'b0, mon_pin}, 8'h0);
    ld_cfg = 2'b01;
    pulse(2'b00, 2'b10);
    chk("R9", "ch A fb shown", {7'b0, mon_pin}, 8'h1);
    pulse(2'b10, 2'b00);
    chk("R9", "ch A ref hidden in fb mode", {7'b0, mon_pin}, 8'h0);
    fo_cfg = 2'b01; ld_cfg = 2'b10;
    pulse(2'b01, 2'b00);
    chk("R9", "ch B ref shown, ld[1] ignored", {7'b0, mon_pin}, 8'h1);
    ld_cfg = 2'b11;
    pulse(2'b01, 2'b00);
    chk("R9", "ch B ref hidden", {7'b0, mon_pin}, 8'h0);
    pulse(2'b00, 2'b01);
    chk("R9", "ch B fb shown", {7'b0, mon_pin}, 8'h1);
    clear_all();
  endtask

  task automatic test_clear_r10();
    fo_cfg = 2'b11;
    ld_cfg = 2'b01; step();
    chk("R10", "clear ch B", {6'b0, ctr_clr}, 8'h1);
    chk("R10", "pin low", {7'b0, mon_pin}, 8'h0);
    ld_cfg = 2'b10; step();
    chk("R10", "clear ch A", {6'b0, ctr_clr}, 8'h2);
    ld_cfg = 2'b11; step();
    chk("R10", "clear both", {6'b0, ctr_clr}, 8'h3);
    ld_cfg = 2'b00; step();
    chk("R10", "clear none", {6'b0, ctr_clr}, 8'h0);
    fo_cfg = 2'b00; ld_cfg = 2'b11; step();
    chk("R10", "no clear in lock mode", {6'b0, ctr_clr}, 8'h0);
    fo_cfg = 2'b00; ld_cfg = 2'b00;
  endtask

  initial begin
    step(3);
    test_reset();
    rst_n = 1'b1;
    step();
    test_pfd_r1_r2();
    test_float_r3();
    test_pd_r4();
    test_pump_r11();
    test_lock_r5_r6_r7();
    test_lock_select_r8();
    test_divider_r9();
    test_clear_r10();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule